// File: doc/BRIEF.md
# Cursor and crosshair overlay generator

The block receives the raster position of the pixel being generated, together with a command byte and a set of position and window registers, and returns per-pixel overlay controls for a display pipeline. Two overlays are produced. The first is a 64 by 64 bitmap cursor, two bits per pixel, fetched from an internal 512-word by 16-bit pattern store. The second is a crosshair built from one vertical and one horizontal band of selectable thickness. Both bands are centred on the cursor anchor and clipped to a rectangular window.

The programmed cursor X is given in screen terms. The block shifts it by a skew that depends on the pixel multiplex mode, and the programmed cursor Y by a fixed 32 lines, to obtain the raster anchor. The enabled overlays are merged by OR or by AND into a single overlay flag. Every output is registered, and each arrives exactly two clocks after the raster position and the configuration it was computed from. Sync generation and colour lookup lie in neighbouring blocks.

Top module: `ovl_cursor_gen`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `cur_code` is 0, `xh_hit` is 0 and `ovl_hit` is 0.
- R2: With P = 37 for mux code 00 or 11, P = 52 for 01 and P = 57 for 10 (command bits 3:2), let dx = (raster_x − cur_x − P) mod 4096 and dy = (raster_y − cur_y − 32) mod 4096. The pixel lies inside the cursor exactly when dx < 64 and dy < 64.
- R3: Inside the cursor, with command bit 6 set, `cur_code` equals bits [2·(dx mod 8)+1 : 2·(dx mod 8)] of pattern word dy·8 + dx/8. The leftmost pixel of a word is in bits 1:0. Otherwise `cur_code` is 0.
- R4: With h = command bits 1:0, so that the band is 2h+1 pixels thick, the column band holds when (dx + h) mod 4096 ≤ 2h. The row band holds when (dy + h) mod 4096 ≤ 2h.
- R5: `xh_hit` is 1 exactly when command bit 5 is set, the pixel is in the window ((raster_x − win_x) mod 4096 < win_w and (raster_y − win_y) mod 4096 < win_h), and at least one of the two bands holds.
- R6: A window width of 0 or a window height of 0 yields no crosshair pixel at all.
- R7: When command bit 4 is 1, `ovl_hit` = (`cur_code` ≠ 0) OR `xh_hit`. When it is 0, `ovl_hit` = (`cur_code` ≠ 0) AND `xh_hit`.
- R8: Outputs appear 2 clocks after the raster position. The command, cursor and window inputs are sampled in the same cycle as that position.
- R9: A cycle with `pat_we` high stores `pat_wdata` at `pat_addr`. Later cursor fetches see the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raster_x | input | 12 | Current raster column |
| raster_y | input | 12 | Current raster line |
| cmd | input | 8 | Command byte: enables, combine rule, mux mode, thickness |
| cur_x | input | 12 | Programmed cursor X |
| cur_y | input | 12 | Programmed cursor Y |
| win_x | input | 12 | Crosshair window left edge (raster) |
| win_y | input | 12 | Crosshair window top edge (raster) |
| win_w | input | 12 | Crosshair window width, 0 disables |
| win_h | input | 12 | Crosshair window height, 0 disables |
| pat_we | input | 1 | Pattern store write enable |
| pat_addr | input | 9 | Pattern store word address |
| pat_wdata | input | 16 | Pattern store write data |
| cur_code | output | 2 | Cursor pixel code |
| xh_hit | output | 1 | Crosshair pixel flag |
| ovl_hit | output | 1 | Combined overlay flag |

## Verification
The checker watches four properties on every cycle. A cleared enable bit forces its overlay output to zero. A zero-sized window suppresses the crosshair. The merged flag follows the OR or AND rule applied to the two outputs of the same cycle, and the outputs are cleared after reset. The geometry cannot be shown by those properties: the anchor skew for each mux mode, the bit-pair ordering inside a pattern word, the band widths, window clipping and coordinate wrap-around. Only the bench shows these, by sweeping the raster over each cursor and comparing each pixel with an arithmetic model.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    localparam int Y_BIAS = 32;

    typedef enum logic [1:0] {
        MUX_1TO1 = 2'b00,
        MUX_4TO1 = 2'b01,
        MUX_5TO1 = 2'b10,
        MUX_RSVD = 2'b11
    } mux_mode_e;

    typedef struct packed {
        logic      cur_en;
        logic      xh_en;
        logic      comb_or;
        mux_mode_e mux;
        logic [1:0] thick;
    } cmd_t;

    function automatic cmd_t decode_cmd(input logic [7:0] c);
        cmd_t r;
        r.cur_en  = c[6];
        r.xh_en   = c[5];
        r.comb_or = c[4];
        r.mux     = mux_mode_e'(c[3:2]);
        r.thick   = c[1:0];
        return r;
    endfunction

    // horizontal anchor skew for each multiplex mode
    function automatic logic [7:0] skew_of(input mux_mode_e m);
        case (m)
            MUX_4TO1: return 8'd52;
            MUX_5TO1: return 8'd57;
            default:  return 8'd37;
        endcase
    endfunction

endpackage

// File: rtl/ovl_geom.sv
module ovl_geom
    import ovl_pkg::*;
#(
    parameter int CW      = 12,
    parameter int SZ_LOG2 = 6,
    parameter int SEL_W   = 3,
    localparam int AW     = 2 * SZ_LOG2 - SEL_W
) (
    input  logic [CW-1:0]      rx,
    input  logic [CW-1:0]      ry,
    input  logic [CW-1:0]      cx,
    input  logic [CW-1:0]      cy,
    input  logic [CW-1:0]      wx,
    input  logic [CW-1:0]      wy,
    input  logic [CW-1:0]      ww,
    input  logic [CW-1:0]      wh,
    input  cmd_t               cfg,
    output logic               in_cur,
    output logic               xh_raw,
    output logic [AW-1:0]      fetch_addr,
    output logic [SEL_W-1:0]   pix_sel
);
    logic [CW-1:0] px, py, dxf, dyf, half, twice, bx, by, wdx, wdy;
    logic col_band, row_band, in_win;

    always_comb begin
        px    = cx + {{(CW-8){1'b0}}, skew_of(cfg.mux)};
        py    = cy + CW'(Y_BIAS);
        dxf   = rx - px;
        dyf   = ry - py;
        in_cur = (dxf[CW-1:SZ_LOG2] == '0) && (dyf[CW-1:SZ_LOG2] == '0);

        half  = {{(CW-2){1'b0}}, cfg.thick};
        twice = {half[CW-2:0], 1'b0};
        bx    = dxf + half;
        by    = dyf + half;
        col_band = (bx <= twice);
        row_band = (by <= twice);

        wdx    = rx - wx;
        wdy    = ry - wy;
        in_win = (wdx < ww) && (wdy < wh);
        xh_raw = in_win && (col_band || row_band);

        fetch_addr = {dyf[SZ_LOG2-1:0], dxf[SZ_LOG2-1:SEL_W]};
        pix_sel    = dxf[SEL_W-1:0];
    end
endmodule

// File: rtl/ovl_pattern_ram.sv
module ovl_pattern_ram #(
    parameter int AW = 9,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/ovl_pixel_sel.sv
module ovl_pixel_sel #(
    parameter int BPP    = 2,
    parameter int WORD_W = 16,
    parameter int SEL_W  = 3
) (
    input  logic [WORD_W-1:0] word,
    input  logic [SEL_W-1:0]  sel,
    output logic [BPP-1:0]    code
);
    always_comb code = word[int'(sel) * BPP +: BPP];
endmodule

// File: rtl/ovl_cursor_gen.sv
module ovl_cursor_gen
    import ovl_pkg::*;
#(
    parameter int CW      = 12,
    parameter int SZ_LOG2 = 6,
    parameter int BPP     = 2,
    parameter int WORD_W  = 16,
    localparam int SEL_W  = $clog2(WORD_W / BPP),
    localparam int AW     = 2 * SZ_LOG2 - SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     raster_x,
    input  logic [CW-1:0]     raster_y,
    input  logic [7:0]        cmd,
    input  logic [CW-1:0]     cur_x,
    input  logic [CW-1:0]     cur_y,
    input  logic [CW-1:0]     win_x,
    input  logic [CW-1:0]     win_y,
    input  logic [CW-1:0]     win_w,
    input  logic [CW-1:0]     win_h,
    input  logic              pat_we,
    input  logic [AW-1:0]     pat_addr,
    input  logic [WORD_W-1:0] pat_wdata,
    output logic [BPP-1:0]    cur_code,
    output logic              xh_hit,
    output logic              ovl_hit
);
    cmd_t              cfg;
    logic              g_in_cur, g_xh;
    logic [AW-1:0]     g_addr;
    logic [SEL_W-1:0]  g_sel;

    always_comb cfg = decode_cmd(cmd);

    ovl_geom #(.CW(CW), .SZ_LOG2(SZ_LOG2), .SEL_W(SEL_W)) u_geom (
        .rx(raster_x), .ry(raster_y), .cx(cur_x), .cy(cur_y),
        .wx(win_x), .wy(win_y), .ww(win_w), .wh(win_h), .cfg(cfg),
        .in_cur(g_in_cur), .xh_raw(g_xh), .fetch_addr(g_addr), .pix_sel(g_sel)
    );

    // stage 1: geometry results registered alongside the pattern fetch
    logic [WORD_W-1:0] s1_word;
    logic [SEL_W-1:0]  s1_sel;
    logic              s1_cur, s1_xh, s1_or;

    ovl_pattern_ram #(.AW(AW), .DW(WORD_W)) u_ram (
        .clk(clk), .we(pat_we), .waddr(pat_addr), .wdata(pat_wdata),
        .raddr(g_addr), .rdata(s1_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_sel <= '0;
            s1_cur <= 1'b0;
            s1_xh  <= 1'b0;
            s1_or  <= 1'b0;
        end else begin
            s1_sel <= g_sel;
            s1_cur <= g_in_cur && cfg.cur_en;
            s1_xh  <= g_xh && cfg.xh_en;
            s1_or  <= cfg.comb_or;
        end
    end

    // stage 2: bit-pair selection and overlay merge
    logic [BPP-1:0] pix;
    logic [BPP-1:0] code_n;
    logic           any_cur, merged;

    ovl_pixel_sel #(.BPP(BPP), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_sel (
        .word(s1_word), .sel(s1_sel), .code(pix)
    );

    always_comb begin
        code_n  = s1_cur ? pix : '0;
        any_cur = |code_n;
        merged  = s1_or ? (any_cur || s1_xh) : (any_cur && s1_xh);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_code <= '0;
            xh_hit   <= 1'b0;
            ovl_hit  <= 1'b0;
        end else begin
            cur_code <= code_n;
            xh_hit   <= s1_xh;
            ovl_hit  <= merged;
        end
    end
endmodule

// File: rtl/ovl_cursor_gen_chk.sv
module ovl_cursor_gen_chk #(
    parameter int CW  = 12,
    parameter int BPP = 2
) (
    input logic           clk,
    input logic           rst,
    input logic [7:0]     cmd,
    input logic [CW-1:0]  win_w,
    input logic [CW-1:0]  win_h,
    input logic [BPP-1:0] cur_code,
    input logic           xh_hit,
    input logic           ovl_hit
);
    logic [1:0] warm_cnt;
    logic       warm;

    always_ff @(posedge clk) begin
        if (rst) warm_cnt <= '0;
        else if (warm_cnt != 2'd2) warm_cnt <= warm_cnt + 2'd1;
    end
    assign warm = (warm_cnt == 2'd2);

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cur_code == '0 && !xh_hit && !ovl_hit));

    a_r3_cursor_disabled: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(cmd[6], 2)) |-> (cur_code == '0));

    a_r5_xhair_disabled: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(cmd[5], 2)) |-> !xh_hit);

    a_r6_empty_window: assert property (@(posedge clk) disable iff (rst)
        (warm && ($past(win_w, 2) == '0 || $past(win_h, 2) == '0)) |-> !xh_hit);

    a_r7_or_merge: assert property (@(posedge clk) disable iff (rst)
        (warm && $past(cmd[4], 2)) |-> (ovl_hit == ((cur_code != '0) || xh_hit)));

    a_r7_and_merge: assert property (@(posedge clk) disable iff (rst)
        (warm && !$past(cmd[4], 2)) |-> (ovl_hit == ((cur_code != '0) && xh_hit)));
endmodule

bind ovl_cursor_gen ovl_cursor_gen_chk #(.CW(CW), .BPP(BPP)) u_chk (
    .clk(clk), .rst(rst), .cmd(cmd), .win_w(win_w), .win_h(win_h),
    .cur_code(cur_code), .xh_hit(xh_hit), .ovl_hit(ovl_hit)
);

// File: tb/sim_ovl_cursor_gen.sv
module sim_ovl_cursor_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] raster_x = '0, raster_y = '0;
    logic [7:0]  cmd = '0;
    logic [11:0] cur_x = '0, cur_y = '0, win_x = '0, win_y = '0, win_w = '0, win_h = '0;
    logic        pat_we = 1'b0;
    logic [8:0]  pat_addr = '0;
    logic [15:0] pat_wdata = '0;
    logic [1:0]  cur_code;
    logic        xh_hit, ovl_hit;

    always #(CLK_PERIOD/2) clk = ~clk;

    ovl_cursor_gen u0 (
        .clk(clk), .rst(rst), .raster_x(raster_x), .raster_y(raster_y), .cmd(cmd),
        .cur_x(cur_x), .cur_y(cur_y), .win_x(win_x), .win_y(win_y),
        .win_w(win_w), .win_h(win_h), .pat_we(pat_we), .pat_addr(pat_addr),
        .pat_wdata(pat_wdata), .cur_code(cur_code), .xh_hit(xh_hit), .ovl_hit(ovl_hit)
    );

    int n_chk = 0, n_err = 0;
    logic [15:0] pat_m [512];
    logic [7:0]  cmd_b;
    logic [11:0] cx_b, cy_b, wx_b, wy_b, ww_b, wh_b;

    logic       q1_v = 1'b0, q2_v = 1'b0;
    logic [3:0] q1, q2;
    string      q1_r, q2_r;

    function automatic int skew_p(input logic [1:0] m);
        return (m == 2'b01) ? 52 : (m == 2'b10) ? 57 : 37;
    endfunction

    function automatic logic [3:0] model(input logic [11:0] x, input logic [11:0] y);
        logic [11:0] dx, dy, h, bx, by, wdx, wdy;
        logic in_c, col, row, win, xh, ov;
        logic [1:0] code;
        logic [15:0] w;
        int idx;
        dx = x - cx_b - 12'(skew_p(cmd_b[3:2]));
        dy = y - cy_b - 12'd32;
        in_c = (dx < 12'd64) && (dy < 12'd64);
        code = 2'b00;
        if (in_c && cmd_b[6]) begin
            idx  = int'(dy) * 8 + int'(dx) / 8;
            w    = pat_m[idx];
            code = 2'((w >> (2 * (int'(dx) % 8))) & 16'd3);
        end
        h   = {10'd0, cmd_b[1:0]};
        bx  = dx + h;
        by  = dy + h;
        col = bx <= 12'(2 * int'(h));
        row = by <= 12'(2 * int'(h));
        wdx = x - wx_b;
        wdy = y - wy_b;
        win = (wdx < ww_b) && (wdy < wh_b);
        xh  = cmd_b[5] && win && (col || row);
        ov  = cmd_b[4] ? ((code != 0) || xh) : ((code != 0) && xh);
        return {code, xh, ov};
    endfunction

    task automatic check(input logic [3:0] act, input logic [3:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: {code,xh,ovl} actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic tick(input logic [11:0] x, input logic [11:0] y, input string req);
        @(negedge clk);
        if (q2_v) check({cur_code, xh_hit, ovl_hit}, q2, q2_r);
        q2_v = q1_v; q2 = q1; q2_r = q1_r;
        q1_v = 1'b1; q1 = model(x, y); q1_r = req;
        raster_x = x; raster_y = y; cmd = cmd_b;
        cur_x = cx_b; cur_y = cy_b; win_x = wx_b; win_y = wy_b; win_w = ww_b; win_h = wh_b;
    endtask

    task automatic drain();
        tick(12'd0, 12'd0, "R8 drain");
        tick(12'd0, 12'd0, "R8 drain");
        q1_v = 1'b0;
        q2_v = 1'b0;
    endtask

    task automatic set_cfg(input logic [7:0] c, input logic [11:0] cx, input logic [11:0] cy,
                           input logic [11:0] wx, input logic [11:0] wy,
                           input logic [11:0] ww, input logic [11:0] wh);
        cmd_b = c; cx_b = cx; cy_b = cy; wx_b = wx; wy_b = wy; ww_b = ww; wh_b = wh;
    endtask

    task automatic sweep(input string req);
        logic [11:0] px, py;
        px = cx_b + 12'(skew_p(cmd_b[3:2]));
        py = cy_b + 12'd32;
        for (int j = -6; j <= 70; j += 2)
            for (int i = -12; i <= 75; i++)
                tick(px + 12'(i), py + 12'(j), req);
        drain();
    endtask

    task automatic write_word(input int a, input logic [15:0] d);
        @(negedge clk);
        pat_we = 1'b1; pat_addr = 9'(a); pat_wdata = d;
        pat_m[a] = d;
        @(negedge clk);
        pat_we = 1'b0;
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        // R1: hold reset with overlay-producing inputs, outputs must stay zero
        cmd = 8'h7F; raster_x = 12'd37; raster_y = 12'd32; win_w = 12'd100; win_h = 12'd100;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check({cur_code, xh_hit, ovl_hit}, 4'b0000, "R1 in reset");
        end
        rst = 1'b0;
        @(negedge clk);
        check({cur_code, xh_hit, ovl_hit}, 4'b0000, "R1 after reset");

        // R9: load the whole pattern store
        for (int a = 0; a < 512; a++)
            write_word(a, 16'((a * 40503) ^ (a << 5) ^ 16'h5A3C));

        // R2 R3 R4 R5 R7 R8: OR merge, 1:1, thickness 1, wide window
        set_cfg(8'b0111_0000, 12'd100, 12'd40, 12'd0, 12'd0, 12'd4000, 12'd4000);
        sweep("R2 R3 R4 R5 R7 R8 or/1to1/t1");
        // AND merge, 4:1, thickness 3, clipping window
        set_cfg(8'b0110_0101, 12'd300, 12'd200, 12'd362, 12'd229, 12'd40, 12'd50);
        sweep("R2 R3 R4 R5 R7 R8 and/4to1/t3");
        // OR merge, 5:1, thickness 7, clipping window
        set_cfg(8'b0111_1011, 12'd500, 12'd700, 12'd540, 12'd700, 12'd70, 12'd30);
        sweep("R2 R4 R5 R7 R8 or/5to1/t7");
        // reserved mux code behaves as 1:1; cursor wraps at 4096
        set_cfg(8'b0111_1110, 12'd4090, 12'd4080, 12'd4000, 12'd4050, 12'd200, 12'd200);
        sweep("R2 R4 R5 R8 rsvd/wrap/t5");
        // R6: zero width, then zero height
        set_cfg(8'b0111_0011, 12'd100, 12'd40, 12'd0, 12'd0, 12'd0, 12'd4000);
        sweep("R6 zero width");
        set_cfg(8'b0111_0011, 12'd100, 12'd40, 12'd0, 12'd0, 12'd4000, 12'd0);
        sweep("R6 zero height");
        // R3 and R5 enables off
        set_cfg(8'b0011_0001, 12'd100, 12'd40, 12'd0, 12'd0, 12'd4000, 12'd4000);
        sweep("R3 cursor disabled");
        set_cfg(8'b0101_0001, 12'd100, 12'd40, 12'd0, 12'd0, 12'd4000, 12'd4000);
        sweep("R5 crosshair disabled");

        // R9: overwrite one word and revisit its pixels
        write_word(8 * 5 + 2, 16'hE4E4);
        set_cfg(8'b0101_0000, 12'd100, 12'd40, 12'd0, 12'd0, 12'd4000, 12'd4000);
        for (int i = 16; i < 24; i++)
            tick(12'd137 + 12'(i), 12'd72 + 12'd5, "R9 rewritten word");
        drain();

        finish_run();
    end
endmodule